// File: doc/BRIEF.md
# Serial Program Counter with Return Stack

This block holds the 16-bit instruction address of a small bit-serial processor. The upper 4 bits choose one of 16 banks of 4K words, and the lower 12 bits give the word within the bank. Moving to the next instruction runs the lower 12 bits through a single one-bit half adder, one bit per clock with the least significant bit first. The carry starts at 1 and is held between bit steps. A wrap of the low field never changes the bank bits, which change only when a full address is loaded.

Operations arrive on a valid/ready request channel. A request is accepted on a clock edge where `op_valid` and `op_ready` are both high. The requester keeps `op_valid`, `op_code`, `load_addr` and `irq_en` stable until the request is accepted. `op_ready` is low while a serial pass is in progress, and that is the only back-pressure the block applies. The operations are:

- advance to the next instruction;
- skip the next instruction;
- jump;
- call, which saves the address after the call and then jumps;
- return from a call;
- interrupt entry, which saves the current address and jumps to a fixed vector.

Return addresses go into a built-in stack of three entries, arranged as a ring.

Top module: `serial_pc_stack`

## Requirements
- R1: After reset, `pc` is 0x0000, `op_ready` is 1 and `underflow` is 0, and the stack is empty.
- R2: Requests with codes 0, 1 and 3 hold `op_ready` low for exactly 12 (code 0 and 3) or 24 (code 1) cycles after acceptance, and `pc` does not change while `op_ready` is low. All other codes leave `op_ready` high. A request held against back-pressure is accepted once `op_ready` returns.
- R3: Code 0 (advance) sets `pc[11:0]` to `pc[11:0]+1` modulo 4096. `pc[15:12]` is unchanged. The new value appears 12 cycles after acceptance.
- R4: Code 1 (skip) adds 2 to `pc[11:0]` modulo 4096, keeps `pc[15:12]`, and the new value appears 24 cycles after acceptance.
- R5: Code 2 (jump) loads all 16 bits of `load_addr` into `pc` on the cycle after acceptance.
- R6: Code 3 (call) pushes `{pc[15:12], pc[11:0]+1 mod 4096}` and loads the `load_addr` captured at acceptance. Both take effect 12 cycles after acceptance.
- R7: Code 4 (return) loads `pc` from the newest stack entry and removes that entry, on the cycle after acceptance.
- R8: A push onto a full stack discards the oldest entry. Later returns yield the three newest entries, newest first.
- R9: A return on an empty stack still steps the ring pointer down and loads the slot it lands on. It also sets `underflow`, which stays 1 until reset.
- R10: Code 5 with `irq_en` = 1 pushes the current `pc` and loads 0x0004 on the cycle after acceptance.
- R11: Code 5 with `irq_en` = 0 changes neither `pc` nor the stack.
- R12: Codes 6 and 7 change neither `pc` nor the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation request valid |
| op_ready | output | 1 | Block can accept a request |
| op_code | input | 3 | 0 advance, 1 skip, 2 jump, 3 call, 4 return, 5 interrupt |
| load_addr | input | 16 | Target for jump and call |
| irq_en | input | 1 | Interrupt entry allowed |
| pc | output | 16 | Current instruction address |
| underflow | output | 1 | Sticky flag: a return was made on an empty stack |

## Verification
When a call's serial pass completes, the push of its return address and the load of its target happen on the same edge. If the stack is already full, that same edge also overwrites the oldest entry. The bench provokes this with four calls in a row. Each call is presented while the previous pass is still running, so the request is held against back-pressure and is accepted on the cycle after the previous commit. A behavioural model compares `pc`, `op_ready` and `underflow` on every cycle. The following returns must yield the three newest return addresses, and then the stale ring slot together with `underflow`.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef enum logic [2:0] {
    OP_INC  = 3'd0,
    OP_SKIP = 3'd1,
    OP_JUMP = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_IRQ  = 3'd5
  } pc_op_e;
endpackage

// File: rtl/spc_serial_inc.sv
// One-bit half adder walking a rotating copy of the low address field.
module spc_serial_inc #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         two_pass,
  input  logic [W-1:0] seed,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  work;
  logic          carry;
  logic [CW-1:0] step;
  logic          again;
  logic          sum_bit;
  logic          last_step;

  assign sum_bit   = work[0] ^ carry;
  assign result    = {sum_bit, work[W-1:1]};
  assign last_step = busy && (step == CW'(W-1));
  assign done      = last_step && !again;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work  <= '0;
      carry <= 1'b0;
      step  <= '0;
      again <= 1'b0;
      busy  <= 1'b0;
    end else if (start && !busy) begin
      work  <= seed;
      carry <= 1'b1;
      step  <= '0;
      again <= two_pass;
      busy  <= 1'b1;
    end else if (busy) begin
      work <= result;
      if (last_step) begin
        step  <= '0;
        carry <= 1'b1;
        again <= 1'b0;
        busy  <= again;
      end else begin
        step  <= step + 1'b1;
        carry <= work[0] & carry;
      end
    end
  end
endmodule

// File: rtl/spc_ring_stack.sv
// Return-address ring: a full push overwrites the oldest slot.
module spc_ring_stack #(
  parameter int AW    = 16,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] top_data,
  output logic          empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] slot [DEPTH];
  logic [PW-1:0] wp;
  logic [PW-1:0] wp_dn;
  logic [PW-1:0] wp_up;
  logic [CW-1:0] fill;

  assign wp_dn    = (wp == '0) ? PW'(DEPTH - 1) : wp - 1'b1;
  assign wp_up    = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
  assign top_data = slot[wp_dn];
  assign empty    = (fill == '0);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot[i] <= '0;
      else if (push && wp == PW'(i))
        slot[i] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      fill <= '0;
    end else if (push) begin
      wp <= wp_up;
      if (fill != CW'(DEPTH)) fill <= fill + 1'b1;
    end else if (pop) begin
      wp <= wp_dn;
      if (fill != '0) fill <= fill - 1'b1;
    end
  end
endmodule

// File: rtl/serial_pc_stack.sv
module serial_pc_stack #(
  parameter int              PC_W       = 16,
  parameter int              LO_W       = 12,
  parameter int              DEPTH      = 3,
  parameter logic [PC_W-1:0] IRQ_VECTOR = 16'h0004,
  parameter logic [PC_W-1:0] RESET_PC   = 16'h0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [2:0]      op_code,
  input  logic [PC_W-1:0] load_addr,
  input  logic            irq_en,
  output logic [PC_W-1:0] pc,
  output logic            underflow
);
  import spc_pkg::*;

  localparam int BANK_W = PC_W - LO_W;

  logic            accept;
  logic            start_ser;
  logic            inc_busy;
  logic            inc_done;
  logic [LO_W-1:0] inc_res;
  logic            call_pend;
  logic [PC_W-1:0] target;
  logic            irq_take;
  logic            st_push;
  logic            st_pop;
  logic [PC_W-1:0] st_wdata;
  logic [PC_W-1:0] st_top;
  logic            st_empty;
  logic [BANK_W-1:0] bank;

  assign bank      = pc[PC_W-1:LO_W];
  assign op_ready  = !inc_busy;
  assign accept    = op_valid && op_ready;
  assign start_ser = accept && (op_code == OP_INC || op_code == OP_SKIP ||
                                op_code == OP_CALL);
  assign irq_take  = accept && op_code == OP_IRQ && irq_en;
  assign st_pop    = accept && op_code == OP_RET;
  assign st_push   = irq_take || (inc_done && call_pend);
  assign st_wdata  = irq_take ? pc : {bank, inc_res};

  spc_serial_inc #(.W(LO_W)) u_inc (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_ser),
    .two_pass (op_code == OP_SKIP),
    .seed     (pc[LO_W-1:0]),
    .busy     (inc_busy),
    .done     (inc_done),
    .result   (inc_res)
  );

  spc_ring_stack #(.AW(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (st_push),
    .push_data (st_wdata),
    .pop       (st_pop),
    .top_data  (st_top),
    .empty     (st_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      call_pend <= 1'b0;
      target    <= '0;
    end else if (start_ser) begin
      call_pend <= (op_code == OP_CALL);
      target    <= load_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= RESET_PC;
    end else if (inc_done) begin
      if (call_pend) pc <= target;
      else           pc <= {bank, inc_res};
    end else if (accept) begin
      case (op_code)
        OP_JUMP: pc <= load_addr;
        OP_RET:  pc <= st_top;
        OP_IRQ:  if (irq_en) pc <= IRQ_VECTOR;
        default: pc <= pc;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 underflow <= 1'b0;
    else if (st_pop && st_empty) underflow <= 1'b1;
  end
endmodule

// File: rtl/spc_checker.sv
module spc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic        op_ready,
  input logic [2:0]  op_code,
  input logic [15:0] load_addr,
  input logic        irq_en,
  input logic [15:0] pc,
  input logic        underflow
);
  import spc_pkg::*;

  logic [2:0] last_code;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    last_code <= 3'd0;
    else if (op_valid && op_ready) last_code <= op_code;
  end

  a_r2_serial_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && (op_code == OP_INC || op_code == OP_SKIP ||
     op_code == OP_CALL)) |=> !op_ready);

  a_r2_pc_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !op_ready |-> $stable(pc));

  a_r3_bank_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(op_ready) && last_code != OP_CALL) |-> pc[15:12] == $past(pc[15:12]));

  a_r5_jump_load: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_code == OP_JUMP) |=> pc == $past(load_addr));

  a_r9_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  a_r10_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_code == OP_IRQ && irq_en) |=> pc == 16'h0004);

  a_r11_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_code == OP_IRQ && !irq_en) |=> $stable(pc));

  a_r12_unused_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_code[2:1] == 2'b11) |=> $stable(pc));
endmodule

bind serial_pc_stack spc_checker u_spc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_ready  (op_ready),
  .op_code   (op_code),
  .load_addr (load_addr),
  .irq_en    (irq_en),
  .pc        (pc),
  .underflow (underflow)
);

// File: tb/serial_pc_stack_bench.sv
module serial_pc_stack_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [2:0]  op_code = 3'd0;
  logic [15:0] load_addr = 16'h0;
  logic        irq_en = 1'b0;
  logic [15:0] pc;
  logic        underflow;

  always #2.5 clk = ~clk;

  serial_pc_stack u_serial_pc_stack (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .load_addr(load_addr), .irq_en(irq_en),
    .pc(pc), .underflow(underflow)
  );

  int    checks = 0;
  int    failures = 0;
  bit    done_flag = 0;
  bit    cmp_on = 0;
  string cur_req = "R1";

  // behavioural reference model
  logic [15:0] m_pc;
  logic [15:0] m_mem [3];
  int          m_wp, m_cnt, m_busy;
  bit          m_uf, m_call;
  logic [15:0] m_res, m_tgt;

  function automatic logic [15:0] bump(logic [15:0] a, int n);
    return (a & 16'hF000) | ((a + 16'(n)) & 16'h0FFF);
  endfunction

  task automatic m_push(logic [15:0] v);
    m_mem[m_wp] = v;
    m_wp = (m_wp + 1) % 3;
    if (m_cnt < 3) m_cnt++;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 16'h0; m_wp = 0; m_cnt = 0; m_busy = 0; m_uf = 0; m_call = 0;
      m_res = 0; m_tgt = 0;
      for (int i = 0; i < 3; i++) m_mem[i] = 16'h0;
    end else if (m_busy > 0) begin
      m_busy--;
      if (m_busy == 0) begin
        if (m_call) begin m_push(m_res); m_pc = m_tgt; end
        else m_pc = m_res;
      end
    end else if (op_valid) begin
      case (op_code)
        3'd0: begin m_busy = 12; m_call = 0; m_res = bump(m_pc, 1); end
        3'd1: begin m_busy = 24; m_call = 0; m_res = bump(m_pc, 2); end
        3'd2: m_pc = load_addr;
        3'd3: begin m_busy = 12; m_call = 1; m_res = bump(m_pc, 1); m_tgt = load_addr; end
        3'd4: begin
          if (m_cnt == 0) m_uf = 1; else m_cnt--;
          m_wp = (m_wp + 2) % 3;
          m_pc = m_mem[m_wp];
        end
        3'd5: if (irq_en) begin m_push(m_pc); m_pc = 16'h0004; end
        default: ;
      endcase
    end
  end

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on && !done_flag) begin
      chk(pc == m_pc, {cur_req, " pc vs model"}, pc, m_pc);
      chk(op_ready == (m_busy == 0), {cur_req, " ready vs model"},
          16'(op_ready), 16'(m_busy == 0));
      chk(underflow == m_uf, {cur_req, " underflow vs model"},
          16'(underflow), 16'(m_uf));
    end
  end

  task automatic do_op(input logic [2:0] c, input logic [15:0] a, input logic ie);
    logic r;
    @(negedge clk);
    op_valid = 1'b1; op_code = c; load_addr = a; irq_en = ie;
    do begin
      r = op_ready;
      @(posedge clk);
      if (!r) @(negedge clk);
    end while (!r);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!op_ready) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", pc, m_pc);
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1;
    // R1 reset state
    chk(pc == 16'h0000, "R1 reset pc", pc, 16'h0);
    chk(op_ready == 1'b1, "R1 reset ready", 16'(op_ready), 16'h1);
    chk(underflow == 1'b0, "R1 reset underflow", 16'(underflow), 16'h0);

    cur_req = "R5";
    do_op(3'd2, 16'h3FFE, 1'b0);
    chk(pc == 16'h3FFE, "R5 jump", pc, 16'h3FFE);

    cur_req = "R3";
    do_op(3'd0, 16'h0, 1'b0);
    n = 1;
    while (!op_ready) begin @(negedge clk); if (!op_ready) n++; end
    chk(n == 12, "R2 advance busy cycles", 16'(n), 16'd12);
    chk(pc == 16'h3FFF, "R3 advance", pc, 16'h3FFF);
    do_op(3'd0, 16'h0, 1'b0); wait_idle();
    chk(pc == 16'h3000, "R3 wrap keeps bank", pc, 16'h3000);

    cur_req = "R4";
    do_op(3'd2, 16'h2FFF, 1'b0);
    do_op(3'd1, 16'h0, 1'b0);
    n = 1;
    while (!op_ready) begin @(negedge clk); if (!op_ready) n++; end
    chk(n == 24, "R2 skip busy cycles", 16'(n), 16'd24);
    chk(pc == 16'h2001, "R4 skip wrap", pc, 16'h2001);
    do_op(3'd1, 16'h0, 1'b0);
    // R2 request held against back-pressure
    do_op(3'd2, 16'h2002, 1'b0);
    chk(pc == 16'h2002, "R2 held jump", pc, 16'h2002);

    cur_req = "R6";
    do_op(3'd3, 16'h5100, 1'b0); wait_idle();
    chk(pc == 16'h5100, "R6 call target", pc, 16'h5100);
    cur_req = "R7";
    do_op(3'd4, 16'h0, 1'b0);
    chk(pc == 16'h2003, "R7 return", pc, 16'h2003);

    cur_req = "R10";
    do_op(3'd5, 16'h0, 1'b1);
    chk(pc == 16'h0004, "R10 irq vector", pc, 16'h0004);
    do_op(3'd4, 16'h0, 1'b0);
    chk(pc == 16'h2003, "R10 irq return", pc, 16'h2003);

    cur_req = "R11";
    do_op(3'd3, 16'h6200, 1'b0); wait_idle();
    do_op(3'd5, 16'h0, 1'b0);
    chk(pc == 16'h6200, "R11 masked irq pc", pc, 16'h6200);
    cur_req = "R12";
    do_op(3'd6, 16'h1111, 1'b0);
    do_op(3'd7, 16'h2222, 1'b0);
    chk(pc == 16'h6200, "R12 unused codes pc", pc, 16'h6200);
    do_op(3'd4, 16'h0, 1'b0);
    chk(pc == 16'h2004, "R11 R12 stack untouched", pc, 16'h2004);
    chk(underflow == 1'b0, "R11 no underflow", 16'(underflow), 16'h0);

    cur_req = "R8";
    do_op(3'd3, 16'h7010, 1'b0);
    do_op(3'd3, 16'h7020, 1'b0);
    do_op(3'd3, 16'h7030, 1'b0);
    do_op(3'd3, 16'h7040, 1'b0); wait_idle();
    chk(pc == 16'h7040, "R8 fourth call", pc, 16'h7040);
    do_op(3'd4, 16'h0, 1'b0);
    chk(pc == 16'h7031, "R8 pop newest", pc, 16'h7031);
    do_op(3'd4, 16'h0, 1'b0);
    chk(pc == 16'h7021, "R8 pop second", pc, 16'h7021);
    do_op(3'd4, 16'h0, 1'b0);
    chk(pc == 16'h7011, "R8 pop third", pc, 16'h7011);
    cur_req = "R9";
    do_op(3'd4, 16'h0, 1'b0);
    chk(underflow == 1'b1, "R9 underflow set", 16'(underflow), 16'h1);
    chk(pc == 16'h7031, "R9 stale ring slot", pc, 16'h7031);
    do_op(3'd2, 16'h0100, 1'b0);
    chk(underflow == 1'b1, "R9 underflow sticky", 16'(underflow), 16'h1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule